// File: doc/BRIEF.md
# Bus Handshake Protocol Checker

This block is a passive monitor for a parallel, multiplexed PCI-style bus. It samples five handshake lines on every rising clock edge: frame, initiator-ready, target-ready, stop and device-select. From those samples it reconstructs where the bus is in a transaction: idle, the address clock, or one of the data clocks that follow. It drives nothing onto the bus. All lines are taken as active high at the monitor's pins, so any inversion for active-low signalling happens outside the block.

The monitor pulses an output for every data beat that moves, and another when a transaction's final phase completes. At that end point it publishes the number of beats the transaction carried. It also enforces the commitment rules of the handshake. An initiator that has raised initiator-ready must hold both that line and frame until the phase completes. A target that has raised target-ready or stop must hold device-select, target-ready and stop until the phase completes. Breaking either rule sets a sticky error flag. So does driving initiator-ready outside a transaction, and so does driving it during the address clock. A 3-bit code keeps the first error seen until a synchronous clear pulse.

A fast back-to-back address clock, directly after a transaction's final completion with no idle clock between, is accepted as legal.

Top module: `hshk_monitor`

## Requirements
- R1: After reset, bus_state_o is 0 (idle), beat_o and txn_end_o are low, and beat_count_o, err_flags_o and err_code_o are all zero.
- R2: bus_state_o reports the clock sampled at the last rising edge: 0 = idle, 1 = address, 2 = data. When no transaction is open, a clock with frame asserted is an address clock. Every clock after it is a data clock until the transaction ends. A clock outside a transaction with frame negated is idle.
- R3: beat_o is high, one edge after sampling, for each data clock in which initiator-ready and target-ready are both asserted.
- R4: A data phase completes when initiator-ready is asserted together with target-ready or stop. Completion with frame negated ends the transaction: txn_end_o pulses and the next clock is idle or, with frame asserted, a new address clock that raises no error.
- R5: beat_count_o changes only in the clock where txn_end_o pulses. It then holds the number of beats in that transaction, including the last one, saturating at 2^CNT_W-1 (255 by default). A stop-only ending with no beats gives 0.
- R6: In a data clock that follows a data clock in which initiator-ready was asserted and the phase did not complete, a change of initiator-ready or frame sets err_flags_o bit 0 (code 1).
- R7: In a data clock that follows a data clock in which target-ready or stop was asserted and the phase did not complete, a change of device-select, target-ready or stop sets err_flags_o bit 1 (code 2).
- R8: Initiator-ready asserted with frame negated while no transaction is open sets err_flags_o bit 2 (code 3), and the clock still counts as idle.
- R9: Initiator-ready asserted in an address clock sets err_flags_o bit 3 (code 4).
- R10: Error flags are sticky and accumulate. err_code_o keeps the code of the first error until mon_clr_i is sampled high. That clear zeroes flags and code, and it overrides an error detected in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_clr_i | input | 1 | Synchronous clear of error flags and code |
| frame_i | input | 1 | Frame, active high |
| irdy_i | input | 1 | Initiator ready, active high |
| trdy_i | input | 1 | Target ready, active high |
| stop_i | input | 1 | Target stop request, active high |
| devsel_i | input | 1 | Device select, active high |
| bus_state_o | output | 2 | Phase of the last sampled clock: 0 idle, 1 address, 2 data |
| beat_o | output | 1 | One-clock pulse per completed data beat |
| txn_end_o | output | 1 | One-clock pulse when the final phase completes |
| beat_count_o | output | CNT_W | Beat total of the most recent finished transaction |
| err_flags_o | output | 4 | Sticky flags: bit0 initiator, bit1 target, bit2 ready while idle, bit3 ready in address |
| err_code_o | output | 3 | Code of the first error since the last clear, 0 if none |

## Verification
The assertions assume that the five bus lines and the clear input are stable, known values at each rising edge, and that reset is held for at least one edge before the first sample is trusted. They do not assume a well-behaved bus: the error paths must stay consistent even when the protocol is broken. The stimulus changes every input only on the falling edge. It holds reset low from time zero and then plays whole transactions, some clean and some that deliberately break one rule at a time, so that each flag is provoked in isolation.

// File: rtl/hshk_pkg.sv
package hshk_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    localparam int unsigned NUM_ERR = 4;
    localparam int unsigned CODE_W  = 3;

    // Flag bit index = code - 1
    typedef enum logic [CODE_W-1:0] {
        EC_NONE      = 3'd0,
        EC_INIT      = 3'd1,
        EC_TGT       = 3'd2,
        EC_IRDY_IDLE = 3'd3,
        EC_IRDY_ADDR = 3'd4
    } err_code_e;

    typedef struct packed {
        logic frame;
        logic irdy;
        logic trdy;
        logic stop;
        logic devsel;
    } bus_sample_t;

endpackage

// File: rtl/hshk_phase_tracker.sv
module hshk_phase_tracker
    import hshk_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_sample_t      bus_i,
    output logic             in_txn_o,
    output logic             done_o,
    output phase_e           phase_o,
    output logic             beat_o,
    output logic             end_o,
    output logic [CNT_W-1:0] count_o,
    output logic             irdy_idle_o,
    output logic             irdy_addr_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             in_txn;
        phase_e           phase;
        logic             beat;
        logic             txn_end;
        logic [CNT_W-1:0] run_cnt;
        logic [CNT_W-1:0] last_cnt;
    } trk_state_t;

    trk_state_t st_d, st_q;

    logic             done_now;
    logic             beat_now;
    logic [CNT_W-1:0] run_next;

    always_comb begin
        done_now = st_q.in_txn && bus_i.irdy && (bus_i.trdy || bus_i.stop);
        beat_now = st_q.in_txn && bus_i.irdy && bus_i.trdy;
        if (beat_now && (st_q.run_cnt != CNT_MAX)) begin
            run_next = st_q.run_cnt + 1'b1;
        end else begin
            run_next = st_q.run_cnt;
        end

        st_d         = st_q;
        st_d.beat    = 1'b0;
        st_d.txn_end = 1'b0;

        if (!st_q.in_txn) begin
            if (bus_i.frame) begin
                st_d.phase   = PH_ADDR;
                st_d.in_txn  = 1'b1;
                st_d.run_cnt = '0;
            end else begin
                st_d.phase = PH_IDLE;
            end
        end else begin
            st_d.phase   = PH_DATA;
            st_d.beat    = beat_now;
            st_d.run_cnt = run_next;
            if (done_now && !bus_i.frame) begin
                st_d.txn_end  = 1'b1;
                st_d.in_txn   = 1'b0;
                st_d.last_cnt = run_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{in_txn: 1'b0, phase: PH_IDLE, beat: 1'b0, txn_end: 1'b0,
                      run_cnt: '0, last_cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign in_txn_o    = st_q.in_txn;
    assign done_o      = done_now;
    assign phase_o     = st_q.phase;
    assign beat_o      = st_q.beat;
    assign end_o       = st_q.txn_end;
    assign count_o     = st_q.last_cnt;
    assign irdy_idle_o = !st_q.in_txn && !bus_i.frame && bus_i.irdy;
    assign irdy_addr_o = !st_q.in_txn && bus_i.frame && bus_i.irdy;

    // R2: an address clock is always followed by a data clock
    assert_addr_then_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_ADDR) |=> (st_q.phase == PH_DATA));

    // R4: after the end pulse the bus is not in a data clock
    assert_end_leaves_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.txn_end |=> (st_q.phase != PH_DATA));

    // R5: the published count only moves on an end pulse
    assert_count_only_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_d.txn_end |=> $stable(st_q.last_cnt));

endmodule

// File: rtl/hshk_commit_guard.sv
module hshk_commit_guard
    import hshk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  bus_sample_t bus_i,
    input  logic        in_txn_i,
    input  logic        done_i,
    output logic        viol_init_o,
    output logic        viol_tgt_o
);

    typedef struct packed {
        bus_sample_t prev;
        logic        init_held;
        logic        tgt_held;
    } grd_state_t;

    grd_state_t gd_d, gd_q;

    always_comb begin
        gd_d.prev      = bus_i;
        gd_d.init_held = in_txn_i && bus_i.irdy && !done_i;
        gd_d.tgt_held  = in_txn_i && (bus_i.trdy || bus_i.stop) && !done_i;

        viol_init_o = gd_q.init_held &&
                      ((bus_i.irdy != gd_q.prev.irdy) || (bus_i.frame != gd_q.prev.frame));
        viol_tgt_o  = gd_q.tgt_held &&
                      ((bus_i.devsel != gd_q.prev.devsel) ||
                       (bus_i.trdy   != gd_q.prev.trdy)   ||
                       (bus_i.stop   != gd_q.prev.stop));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gd_q <= '0;
        end else begin
            gd_q <= gd_d;
        end
    end

    // R6: an initiator commitment can only be pending inside a transaction
    assert_init_hold_in_txn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gd_q.init_held |-> in_txn_i);

    // R7: a target commitment can only be pending inside a transaction
    assert_tgt_hold_in_txn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gd_q.tgt_held |-> in_txn_i);

endmodule

// File: rtl/hshk_err_log.sv
module hshk_err_log
    import hshk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic [NUM_ERR-1:0] viol_i,
    output logic [NUM_ERR-1:0] flags_o,
    output logic [CODE_W-1:0]  code_o
);

    typedef struct packed {
        logic [NUM_ERR-1:0] flags;
        logic [CODE_W-1:0]  code;
    } log_state_t;

    log_state_t lg_d, lg_q;
    logic [CODE_W-1:0] first_code;

    always_comb begin
        first_code = '0;
        for (int k = NUM_ERR - 1; k >= 0; k--) begin
            if (viol_i[k]) begin
                first_code = CODE_W'(k + 1);
            end
        end

        lg_d = lg_q;
        if (clr_i) begin
            lg_d = '0;
        end else begin
            lg_d.flags = lg_q.flags | viol_i;
            if (lg_q.code == '0) begin
                lg_d.code = first_code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lg_q <= '0;
        end else begin
            lg_q <= lg_d;
        end
    end

    assign flags_o = lg_q.flags;
    assign code_o  = lg_q.code;

    // R10: raised flags stay raised until a clear
    assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((lg_q.flags & $past(lg_q.flags)) == $past(lg_q.flags)));

    // R10: the first code is kept until a clear
    assert_code_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((lg_q.code != '0) && !clr_i) |=> $stable(lg_q.code));

    // R10: a nonzero code is always backed by a flag
    assert_code_has_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lg_q.code != '0) |-> (lg_q.flags != '0));

endmodule

// File: rtl/hshk_monitor.sv
module hshk_monitor
    import hshk_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mon_clr_i,
    input  logic                frame_i,
    input  logic                irdy_i,
    input  logic                trdy_i,
    input  logic                stop_i,
    input  logic                devsel_i,
    output logic [1:0]          bus_state_o,
    output logic                beat_o,
    output logic                txn_end_o,
    output logic [CNT_W-1:0]    beat_count_o,
    output logic [NUM_ERR-1:0]  err_flags_o,
    output logic [CODE_W-1:0]   err_code_o
);

    bus_sample_t        bus;
    logic               in_txn;
    logic               done;
    phase_e             phase;
    logic               irdy_idle;
    logic               irdy_addr;
    logic               viol_init;
    logic               viol_tgt;
    logic [NUM_ERR-1:0] viol;

    assign bus = '{frame: frame_i, irdy: irdy_i, trdy: trdy_i,
                   stop: stop_i, devsel: devsel_i};

    hshk_phase_tracker #(.CNT_W(CNT_W)) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_i       (bus),
        .in_txn_o    (in_txn),
        .done_o      (done),
        .phase_o     (phase),
        .beat_o      (beat_o),
        .end_o       (txn_end_o),
        .count_o     (beat_count_o),
        .irdy_idle_o (irdy_idle),
        .irdy_addr_o (irdy_addr)
    );

    hshk_commit_guard u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_i       (bus),
        .in_txn_i    (in_txn),
        .done_i      (done),
        .viol_init_o (viol_init),
        .viol_tgt_o  (viol_tgt)
    );

    assign viol = {irdy_addr, irdy_idle, viol_tgt, viol_init};

    hshk_err_log u_log (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (mon_clr_i),
        .viol_i  (viol),
        .flags_o (err_flags_o),
        .code_o  (err_code_o)
    );

    assign bus_state_o = phase;

    // R4: the end pulse marks a data clock
    assert_end_in_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        txn_end_o |-> (bus_state_o == 2'd2));

    // R3: no beat is reported for an idle or address clock
    assert_beat_in_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_o |-> (bus_state_o == 2'd2));

endmodule

// File: tb/hshk_monitor_tb_top.sv
module hshk_monitor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    typedef struct {
        logic [1:0]       st;
        logic             beat;
        logic             tend;
        logic [CNT_W-1:0] cnt;
        logic [3:0]       flg;
        logic [2:0]       code;
        string            tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic frame = 1'b0, irdy = 1'b0, trdy = 1'b0, stop = 1'b0, devsel = 1'b0;

    logic [1:0]       bus_state;
    logic             beat;
    logic             tend;
    logic [CNT_W-1:0] cnt;
    logic [3:0]       flg;
    logic [2:0]       code;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hshk_monitor #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mon_clr_i(clr),
        .frame_i(frame), .irdy_i(irdy), .trdy_i(trdy), .stop_i(stop), .devsel_i(devsel),
        .bus_state_o(bus_state), .beat_o(beat), .txn_end_o(tend),
        .beat_count_o(cnt), .err_flags_o(flg), .err_code_o(code)
    );

    // Driver: set inputs on the falling edge, queue what must appear after the next rising edge
    task automatic step(input logic f, input logic i, input logic t, input logic s, input logic d,
                        input logic [1:0] st, input logic b, input logic e,
                        input logic [CNT_W-1:0] c, input logic [3:0] fl, input logic [2:0] cd,
                        input string tag, input logic cl = 1'b0);
        exp_t x;
        @(negedge clk);
        frame = f; irdy = i; trdy = t; stop = s; devsel = d; clr = cl;
        x.st = st; x.beat = b; x.tend = e; x.cnt = c; x.flg = fl; x.code = cd; x.tag = tag;
        sb_q.push_back(x);
    endtask

    // Monitor: compare just after each rising edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t x;
            x = sb_q.pop_front();
            checks++;
            if (bus_state !== x.st || beat !== x.beat || tend !== x.tend ||
                cnt !== x.cnt || flg !== x.flg || code !== x.code) begin
                errors++;
                $display("FAIL %s: got st=%0d beat=%0b end=%0b cnt=%0d flg=%b code=%0d exp st=%0d beat=%0b end=%0b cnt=%0d flg=%b code=%0d",
                         x.tag, bus_state, beat, tend, cnt, flg, code,
                         x.st, x.beat, x.tend, x.cnt, x.flg, x.code);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen on an idle clock
        step(0,0,0,0,0, 0,0,0, 0, 4'h0, 0, "R1");

        // R2 R3 R4 R5: two beats with one target wait state
        step(1,0,0,0,0, 1,0,0, 0, 4'h0, 0, "R2 addr");
        step(1,1,0,0,1, 2,0,0, 0, 4'h0, 0, "R2 data wait");
        step(1,1,1,0,1, 2,1,0, 0, 4'h0, 0, "R3 beat1");
        step(0,1,0,0,1, 2,0,0, 0, 4'h0, 0, "R3 last wait");
        step(0,1,1,0,1, 2,1,1, 2, 4'h0, 0, "R5 end cnt2");
        step(0,0,0,0,0, 0,0,0, 2, 4'h0, 0, "R4 idle after");

        // R4: fast back-to-back single beats
        step(1,0,0,0,0, 1,0,0, 2, 4'h0, 0, "R4 addr a");
        step(0,1,1,0,1, 2,1,1, 1, 4'h0, 0, "R4 end a");
        step(1,0,0,0,0, 1,0,0, 1, 4'h0, 0, "R4 b2b addr");
        step(0,1,1,0,1, 2,1,1, 1, 4'h0, 0, "R4 end b");
        step(0,0,0,0,0, 0,0,0, 1, 4'h0, 0, "R4 idle");

        // R4 R5: stop ending with no beats
        step(1,0,0,0,0, 1,0,0, 1, 4'h0, 0, "R4 stop addr");
        step(1,1,0,1,1, 2,0,0, 1, 4'h0, 0, "R4 stop phase");
        step(0,1,0,1,1, 2,0,1, 0, 4'h0, 0, "R5 stop end cnt0");
        step(0,0,0,0,0, 0,0,0, 0, 4'h0, 0, "R4 idle");

        // R6: initiator withdraws ready
        step(1,0,0,0,0, 1,0,0, 0, 4'h0, 0, "R6 addr");
        step(1,1,0,0,1, 2,0,0, 0, 4'h0, 0, "R6 commit");
        step(1,0,0,0,1, 2,0,0, 0, 4'h1, 1, "R6 irdy drop");
        step(0,1,1,0,1, 2,1,1, 1, 4'h1, 1, "R6 finish");
        step(0,0,0,0,0, 0,0,0, 1, 4'h1, 1, "R10 sticky");
        step(0,0,0,0,0, 0,0,0, 1, 4'h0, 0, "R10 clear", 1'b1);

        // R7: target withdraws ready
        step(1,0,0,0,0, 1,0,0, 1, 4'h0, 0, "R7 addr");
        step(1,0,1,0,1, 2,0,0, 1, 4'h0, 0, "R7 commit");
        step(1,0,0,0,1, 2,0,0, 1, 4'h2, 2, "R7 trdy drop");
        step(0,1,1,0,1, 2,1,1, 1, 4'h2, 2, "R7 finish");
        step(0,0,0,0,0, 0,0,0, 1, 4'h0, 0, "R10 clear", 1'b1);

        // R8 R9 R10: ready while idle, then ready in address
        step(0,1,0,0,0, 0,0,0, 1, 4'h4, 3, "R8 irdy idle");
        step(0,0,0,0,0, 0,0,0, 1, 4'h4, 3, "R8 hold");
        step(1,1,0,0,0, 1,0,0, 1, 4'hC, 3, "R9 irdy addr first kept R10");
        step(0,1,1,0,1, 2,1,1, 1, 4'hC, 3, "R9 finish");
        step(0,1,0,0,0, 0,0,0, 1, 4'h0, 0, "R10 clear wins", 1'b1);
        step(0,0,0,0,0, 0,0,0, 1, 4'h0, 0, "R10 idle");

        // R5: saturation of the beat count
        step(1,0,0,0,0, 1,0,0, 1, 4'h0, 0, "R5 sat addr");
        for (int n = 0; n < 300; n++) begin
            step(1,1,1,0,1, 2,1,0, 1, 4'h0, 0, "R5 sat beat");
        end
        step(0,1,1,0,1, 2,1,1, 8'd255, 4'h0, 0, "R5 saturated");
        step(0,0,0,0,0, 0,0,0, 8'd255, 4'h0, 0, "R5 idle");

        @(negedge clk);
        @(negedge clk);
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule